// File: doc/BRIEF.md
# Sort-then-Route Self-Steering Packet Fabric

The block is an N-port parallel switch for fixed-size packets. Each cycle, every inlet presents one slot: a valid flag, a destination outlet number and a payload word. The slots pass through two cascaded networks of two-by-two elements. The first network is a bitonic sorter. Each of its elements compares the keys of two slots and exchanges them when needed. The slots leave the sorter ordered by destination, and all empty slots collect after the last occupied one.

The second network is a shuffle-exchange banyan. In it, each element looks at one destination bit of each packet it holds and steers that packet to its upper or lower output, starting with the most significant bit. Because the banyan only ever receives an ordered, gap-free run of packets, no two packets ever compete for the same internal link. Every decision is made locally, so no central controller is needed.

Every element column is one register stage. Every path through the fabric has the same length, which gives a fixed latency of log2N·(log2N+1)/2 + log2N cycles, and a new batch can be accepted every cycle. The user must ensure that no two valid packets of one batch name the same outlet.

Top module: `bb_fabric`

## Requirements
- R1: A valid packet entering on any inlet with destination d leaves on outlet d with `out_valid[d]` high and its payload unchanged.
- R2: An outlet that no valid packet of a batch addresses shows `out_valid` low and an all-zero payload for that batch.
- R3: The latency from inlet to outlet is exactly log2N·(log2N+1)/2 + log2N clock cycles for every packet, and batches presented on consecutive cycles are each delivered independently.
- R4: For an inlet whose valid flag is low, the destination and payload it presents have no effect on any outlet.
- R5: While reset is held, and until the first batch after reset reaches the outlets, all `out_valid` bits are low and all payloads are zero.
- R6: At the sorter's last stage, the occupied slots form a prefix with strictly increasing destinations. The sort key is {not valid, destination}, so empty slots rank after every valid destination.
- R7: No banyan element ever holds two valid packets that steer toward the same output.
- R8: Every sorter stage and every banyan stage passes on exactly as many valid packets as it received.
- R9: A batch in which all N inlets are valid and the destinations form any permutation is delivered in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N | Valid flag per inlet |
| in_addr | input | N*log2N | Destination outlet per inlet; inlet i uses bits [i*log2N +: log2N] |
| in_data | input | N*DW | Payload per inlet; inlet i uses bits [i*DW +: DW] |
| out_valid | output | N | Valid flag per outlet |
| out_data | output | N*DW | Payload per outlet; outlet j uses bits [j*DW +: DW] |

## Verification
The bench builds the fabric with N=8 and DW=16. This gives 6 sorter stages and 3 banyan stages, for a latency of 9 cycles. At this size, all 40320 full permutations can be streamed back to back, one per cycle, which covers R9 exhaustively under continuous pipelining. Every one of the 256 occupancy masks is also applied, with a shuffled destination set and junk on the empty inlets. A sweep over every single inlet-to-outlet pair completes the stimulus.

// File: rtl/bb_pkg.sv
package bb_pkg;

    // Bitonic schedule: stage s belongs to merge block 2^blk, compares at distance 2^dist.
    function automatic int stg_blk(input int s);
        int c;
        int r;
        c = 0;
        r = 0;
        for (int p = 1; p <= 16; p++) begin
            for (int q = p - 1; q >= 0; q--) begin
                if (c == s) r = p;
                c = c + 1;
            end
        end
        return r;
    endfunction

    function automatic int stg_dist(input int s);
        int c;
        int r;
        c = 0;
        r = 0;
        for (int p = 1; p <= 16; p++) begin
            for (int q = p - 1; q >= 0; q--) begin
                if (c == s) r = q;
                c = c + 1;
            end
        end
        return r;
    endfunction

    // Perfect shuffle: rotate an nb-bit line index left by one.
    function automatic int rot_left(input int p, input int nb);
        return ((p << 1) | (p >> (nb - 1))) & ((1 << nb) - 1);
    endfunction

endpackage

// File: rtl/bb_cmpx.sv
module bb_cmpx #(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic [AW+DW:0] a,
    input  logic [AW+DW:0] b,
    input  logic           up,
    output logic [AW+DW:0] lo,
    output logic [AW+DW:0] hi
);
    localparam int W = 1 + AW + DW;

    logic [AW:0] ka;
    logic [AW:0] kb;
    logic        swap;

    always_comb begin
        ka   = {~a[W-1], a[DW +: AW]};
        kb   = {~b[W-1], b[DW +: AW]};
        swap = up ? (ka > kb) : (ka < kb);
        lo   = swap ? b : a;
        hi   = swap ? a : b;
    end
endmodule

// File: rtl/bb_sort_stage.sv
module bb_sort_stage #(
    parameter int N    = 8,
    parameter int DW   = 16,
    parameter int BLK  = 1,
    parameter int DIST = 0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N*(1+$clog2(N)+DW)-1:0]   d_i,
    output logic [N*(1+$clog2(N)+DW)-1:0]   q_o
);
    localparam int AW   = $clog2(N);
    localparam int W    = 1 + AW + DW;
    localparam int SPAN = 1 << DIST;

    logic [N*W-1:0] nxt;
    logic [N-1:0]   vin;
    logic [N-1:0]   vout;
    logic           live;

    for (genvar i = 0; i < N; i++) begin : g_node
        assign vin[i]  = d_i[i*W + W - 1];
        assign vout[i] = q_o[i*W + W - 1];
        if ((i & SPAN) == 0) begin : g_pair
            localparam bit UP = ((i >> BLK) & 1) == 0;
            bb_cmpx #(.AW(AW), .DW(DW)) u_cx (
                .a  (d_i[i*W +: W]),
                .b  (d_i[(i+SPAN)*W +: W]),
                .up (UP),
                .lo (nxt[i*W +: W]),
                .hi (nxt[(i+SPAN)*W +: W])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o  <= '0;
            live <= 1'b0;
        end else begin
            q_o  <= nxt;
            live <= 1'b1;
        end
    end

    assert_sort_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
        live |-> ($countones(vout) == $past($countones(vin))));
endmodule

// File: rtl/bb_switch2.sv
module bb_switch2 #(
    parameter int W = 20
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sa,
    input  logic         sb,
    output logic [W-1:0] up_o,
    output logic [W-1:0] dn_o
);
    logic va;
    logic vb;

    always_comb begin
        va = a[W-1];
        vb = b[W-1];
        if (va && !sa)      up_o = a;
        else if (vb && !sb) up_o = b;
        else                up_o = '0;
        if (va && sa)       dn_o = a;
        else if (vb && sb)  dn_o = b;
        else                dn_o = '0;
    end
endmodule

// File: rtl/bb_route_stage.sv
module bb_route_stage #(
    parameter int N   = 8,
    parameter int DW  = 16,
    parameter int LVL = 0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N*(1+$clog2(N)+DW)-1:0]   d_i,
    output logic [N*(1+$clog2(N)+DW)-1:0]   q_o
);
    localparam int AW  = $clog2(N);
    localparam int W   = 1 + AW + DW;
    localparam int BIT = DW + AW - 1 - LVL;

    logic [N*W-1:0] sh;
    logic [N*W-1:0] nxt;
    logic [N-1:0]   vin;
    logic [N-1:0]   vout;
    logic           live;

    for (genvar p = 0; p < N; p++) begin : g_shuf
        localparam int RP = bb_pkg::rot_left(p, AW);
        assign sh[RP*W +: W] = d_i[p*W +: W];
        assign vin[p]        = d_i[p*W + W - 1];
        assign vout[p]       = q_o[p*W + W - 1];
    end

    for (genvar e = 0; e < N/2; e++) begin : g_elem
        logic [W-1:0] pa;
        logic [W-1:0] pb;
        assign pa = sh[(2*e)*W +: W];
        assign pb = sh[(2*e+1)*W +: W];

        bb_switch2 #(.W(W)) u_sw (
            .a    (pa),
            .b    (pb),
            .sa   (pa[BIT]),
            .sb   (pb[BIT]),
            .up_o (nxt[(2*e)*W +: W]),
            .dn_o (nxt[(2*e+1)*W +: W])
        );

        assert_no_link_clash_R7: assert property (@(posedge clk) disable iff (rst)
            !(pa[W-1] && pb[W-1] && (pa[BIT] == pb[BIT])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o  <= '0;
            live <= 1'b0;
        end else begin
            q_o  <= nxt;
            live <= 1'b1;
        end
    end

    assert_route_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
        live |-> ($countones(vout) == $past($countones(vin))));
endmodule

// File: rtl/bb_fabric.sv
module bb_fabric #(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             in_valid,
    input  logic [N*$clog2(N)-1:0]   in_addr,
    input  logic [N*DW-1:0]          in_data,
    output logic [N-1:0]             out_valid,
    output logic [N*DW-1:0]          out_data
);
    localparam int AW  = $clog2(N);
    localparam int W   = 1 + AW + DW;
    localparam int SS  = AW * (AW + 1) / 2;
    localparam int TOT = SS + AW;

    logic [N*W-1:0] link [0:TOT];

    for (genvar i = 0; i < N; i++) begin : g_pack
        assign link[0][i*W +: W] = {in_valid[i], in_addr[i*AW +: AW], in_data[i*DW +: DW]};
    end

    for (genvar s = 0; s < SS; s++) begin : g_sort
        bb_sort_stage #(
            .N    (N),
            .DW   (DW),
            .BLK  (bb_pkg::stg_blk(s)),
            .DIST (bb_pkg::stg_dist(s))
        ) u_st (
            .clk (clk),
            .rst (rst),
            .d_i (link[s]),
            .q_o (link[s+1])
        );
    end

    for (genvar r = 0; r < AW; r++) begin : g_route
        bb_route_stage #(
            .N   (N),
            .DW  (DW),
            .LVL (r)
        ) u_rt (
            .clk (clk),
            .rst (rst),
            .d_i (link[SS+r]),
            .q_o (link[SS+r+1])
        );
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        assign out_valid[j]         = link[TOT][j*W + W - 1];
        assign out_data[j*DW +: DW] = link[TOT][j*W +: DW];

        assert_lands_on_own_outlet_R1: assert property (@(posedge clk) disable iff (rst)
            link[TOT][j*W + W - 1] |-> (link[TOT][j*W + DW +: AW] == AW'(j)));
    end

    for (genvar i = 0; i < N - 1; i++) begin : g_mono
        assert_sorted_compact_R6: assert property (@(posedge clk) disable iff (rst)
            link[SS][(i+1)*W + W - 1] |->
                (link[SS][i*W + W - 1] &&
                 (link[SS][i*W + DW +: AW] < link[SS][(i+1)*W + DW +: AW])));
    end
endmodule

// File: tb/sim_bb_fabric.sv
module sim_bb_fabric;
    localparam int N   = 8;
    localparam int AW  = 3;
    localparam int DW  = 16;
    localparam int LAT = AW * (AW + 1) / 2 + AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      in_valid = '0;
    logic [N*AW-1:0]   in_addr  = '0;
    logic [N*DW-1:0]   in_data  = '0;
    logic [N-1:0]      out_valid;
    logic [N*DW-1:0]   out_data;

    int total = 0;
    int bad   = 0;
    int bn    = 0;
    bit done  = 1'b0;
    int pa [N];
    logic [31:0] seed = 32'h1234_5678;

    logic [N-1:0]    exp_v [0:15];
    logic [N*DW-1:0] exp_d [0:15];
    string           exp_t [0:15];

    always #2.5 clk = ~clk;

    bb_fabric #(.N(N), .DW(DW)) u0 (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_addr (in_addr), .in_data (in_data),
        .out_valid (out_valid), .out_data (out_data)
    );

    function automatic logic [31:0] nxt_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic verify(input int b);
        int sl;
        logic okv;
        logic okz;
        sl  = b % 16;
        okv = 1'b1;
        okz = 1'b1;
        for (int j = 0; j < N; j++) begin
            if (exp_v[sl][j]) begin
                if (!out_valid[j] || out_data[j*DW +: DW] != exp_d[sl][j*DW +: DW]) okv = 1'b0;
            end else begin
                if (out_valid[j] || out_data[j*DW +: DW] != '0) okz = 1'b0;
            end
        end
        total++;
        if (!okv) begin
            bad++;
            $display("FAIL R1 (%s) batch %0d: valid=%b data=%h exp valid=%b data=%h",
                     exp_t[sl], b, out_valid, out_data, exp_v[sl], exp_d[sl]);
        end
        total++;
        if (!okz) begin
            bad++;
            $display("FAIL R2 (%s) batch %0d: valid=%b data=%h exp valid=%b data=%h",
                     exp_t[sl], b, out_valid, out_data, exp_v[sl], exp_d[sl]);
        end
    endtask

    // One batch per cycle; the batch driven LAT cycles earlier is checked first (R3).
    task automatic step(input logic [N-1:0] m, input string tag);
        int sl;
        @(negedge clk);
        if (bn >= LAT) verify(bn - LAT);
        else begin
            total++;
            if (out_valid != '0 || out_data != '0) begin
                bad++;
                $display("FAIL R5 pre-fill cycle %0d: valid=%b data=%h exp valid=0 data=0",
                         bn, out_valid, out_data);
            end
        end
        sl = bn % 16;
        exp_v[sl] = '0;
        exp_d[sl] = '0;
        exp_t[sl] = tag;
        for (int i = 0; i < N; i++) begin
            seed = nxt_rand(seed);
            in_valid[i] = m[i];
            if (m[i]) begin
                in_addr[i*AW +: AW] = AW'(pa[i]);
                in_data[i*DW +: DW] = {bn[12:0], 3'(i)};
                exp_v[sl][pa[i]] = 1'b1;
                exp_d[sl][pa[i]*DW +: DW] = {bn[12:0], 3'(i)};
            end else begin
                // R4: junk on empty inlets
                in_addr[i*AW +: AW] = seed[AW-1:0];
                in_data[i*DW +: DW] = seed[31:16];
            end
        end
        bn++;
    endtask

    task automatic nperm(output bit more);
        int i;
        int j;
        int t;
        i = N - 2;
        while (i >= 0 && pa[i] >= pa[i+1]) i--;
        if (i < 0) more = 1'b0;
        else begin
            j = N - 1;
            while (pa[j] <= pa[i]) j--;
            t = pa[i]; pa[i] = pa[j]; pa[j] = t;
            for (int a = i + 1, b = N - 1; a < b; a++, b--) begin
                t = pa[a]; pa[a] = pa[b]; pa[b] = t;
            end
            more = 1'b1;
        end
    endtask

    task automatic shuffle();
        int k;
        int t;
        for (int i = 0; i < N; i++) pa[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            seed = nxt_rand(seed);
            k = int'(seed[31:16]) % (i + 1);
            t = pa[i]; pa[i] = pa[k]; pa[k] = t;
        end
    endtask

    initial begin
        bit more;
        // R5: outputs idle while reset is held
        repeat (4) begin
            @(negedge clk);
            total++;
            if (out_valid != '0 || out_data != '0) begin
                bad++;
                $display("FAIL R5 in reset: valid=%b data=%h exp valid=0 data=0", out_valid, out_data);
            end
        end
        rst = 1'b0;

        // R9: every full permutation, back to back
        for (int i = 0; i < N; i++) pa[i] = i;
        more = 1'b1;
        while (more) begin
            step('1, "R9 full permutation");
            nperm(more);
        end

        // R4 / R2: every occupancy mask with shuffled destinations
        for (int m = 0; m < 256; m++) begin
            shuffle();
            step(N'(m), "R4 sparse mask");
        end

        // R1 / R3: each inlet alone to each outlet
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                for (int i = 0; i < N; i++) pa[i] = 0;
                pa[s] = d;
                step(N'(1) << s, "R3 single packet");
            end
        end

        // flush the pipe with empty batches (R2, R3)
        repeat (LAT) step('0, "R3 flush");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: R3 stalled, got no end exp end");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule